// File: doc/BRIEF.md
# Capability Page-Attribute Access Filter

This block stands between a capability-aware load/store unit and the memory port. For every capability-width access it applies the capability attributes of the already translated page. Stores carrying a valid tag to a page that forbids capability stores are stopped with a dedicated fault. Loads go through a three-way page mode (pass, strip tag, fault). A configuration bit chooses whether a load fault may depend on the tag that memory returns, or must be decided from the request alone before any read goes out.

Faults leave as a one-cycle pulse carrying a 5-bit cause and the faulting virtual address, in the form of an ordinary memory fault. Page capability faults use their own causes: 26 for loads and 27 for stores. Any other capability-extension fault seen by translation uses the shared cause 28. A successful load delivers the capability with its adjusted tag. A successful load-conditional also sets a reservation at the access address. Translation, the memory array and the trap vectoring lie outside the block.

Top module: `cap_pte_filter`

## Requirements
- R1: After reset, `req_ready` is high and `ld_valid`, `st_done`, `exc_valid`, `resv_set`, `mem_rd_en` and `mem_wr_en` are all low.
- R2: A translation code on `req_xlat` other than 0 (0 none, 1 store-capability fault, 2 other capability-extension fault, 3 load-capability fault) raises, one cycle after acceptance, a fault with cause 27, 28 or 26 respectively, for loads and stores alike, and issues no memory read or write.
- R3: A store with `req_st_tag` set to a page with `req_st_trap` set raises cause 27 one cycle after acceptance and issues no write.
- R4: A store whose tag is clear, or whose page has `req_st_trap` clear, issues exactly one write one cycle after acceptance, carrying the request's address, tag and data unchanged, together with a `st_done` pulse.
- R5: With `cfg_tag_dep_trap` low, `req_auth_lc` high and a load mode of TRAP, a load raises cause 26 one cycle after acceptance without issuing a read.
- R6: Every other load issues one read one cycle after acceptance and waits for `mem_rd_valid` for as many cycles as that takes. When the returned tag is clear, the capability is delivered unchanged in every mode and no fault is raised.
- R7: Load mode encoding on `req_ld_mode` is 00 OK, 01 CLEAR, 1x TRAP. In OK mode with a set returned tag, the delivered tag equals `req_auth_lc`.
- R8: In CLEAR mode the capability is delivered with its tag forced to zero and its data unchanged.
- R9: In TRAP mode with a set returned tag, a load whose authority grants load-capability raises cause 26 and delivers nothing. Without that grant, the capability is delivered with tag zero.
- R10: A fault reports the request's virtual address on `exc_tval`. Every result (`ld_valid`, `st_done`, `exc_valid`) is a one-cycle pulse, and a fault never coincides with a success.
- R11: For a load with `req_lr` set, `resv_set` pulses together with `ld_valid`, with `resv_addr` equal to the access address. It never pulses for a faulting load or a plain load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_tag_dep_trap | input | 1 | 1: load faults may depend on the returned tag |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Block can accept a request |
| req_store | input | 1 | 1 store, 0 load |
| req_lr | input | 1 | Load-conditional (sets reservation) |
| req_vaddr | input | XLEN | Virtual address of the access |
| req_auth_lc | input | 1 | Authorizing capability grants load-capability |
| req_ld_mode | input | 2 | Page load-capability mode |
| req_st_trap | input | 1 | Page forbids tagged stores |
| req_xlat | input | 2 | Fault code reported by translation |
| req_st_tag | input | 1 | Tag of store data |
| req_st_data | input | CAP_W | Store data |
| mem_rd_en | output | 1 | Read request pulse |
| mem_wr_en | output | 1 | Write request pulse |
| mem_addr | output | XLEN | Memory access address |
| mem_wr_tag | output | 1 | Write tag |
| mem_wr_data | output | CAP_W | Write data |
| mem_rd_valid | input | 1 | Read response valid |
| mem_rd_tag | input | 1 | Returned tag |
| mem_rd_data | input | CAP_W | Returned data |
| ld_valid | output | 1 | Load result pulse |
| ld_tag | output | 1 | Delivered tag |
| ld_data | output | CAP_W | Delivered data |
| st_done | output | 1 | Store forwarded pulse |
| exc_valid | output | 1 | Fault pulse |
| exc_cause | output | 5 | Fault cause |
| exc_tval | output | XLEN | Faulting virtual address |
| resv_set | output | 1 | Reservation set pulse |
| resv_addr | output | XLEN | Reservation address |

## Verification
The hardest case to reach is a TRAP-mode load that must fault only after the read returns. It needs tag-dependent faulting enabled, the load-capability grant, a clean translation and a memory response with the tag set, all on one access. The random stimulus weights the mode toward TRAP, sets the configuration bit half of the time, and inserts random gaps before the response, checking that nothing leaves the block during the gap. Directed cases add the same page mode with the grant removed, with the configuration bit low, and with an untagged response.

// File: rtl/cpf_pkg.sv
package cpf_pkg;
   typedef enum logic [1:0] {
      LM_OK    = 2'b00,
      LM_CLEAR = 2'b01,
      LM_TRAP  = 2'b10,
      LM_TRAP2 = 2'b11
   } ld_mode_e;

   typedef enum logic [1:0] {
      XF_NONE  = 2'd0,
      XF_STCAP = 2'd1,
      XF_EXT   = 2'd2,
      XF_LDCAP = 2'd3
   } xlat_code_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_WAIT = 1'b1
   } fsm_e;
endpackage

// File: rtl/cpf_xlat_map.sv
module cpf_xlat_map
   import cpf_pkg::*;
#(
   parameter int CAUSE_LD  = 26,
   parameter int CAUSE_ST  = 27,
   parameter int CAUSE_GEN = 28
) (
   input  xlat_code_e  code,
   output logic        fault,
   output logic [4:0]  cause
);
   always_comb begin
      fault = 1'b1;
      cause = 5'(CAUSE_GEN);
      unique case (code)
         XF_STCAP: cause = 5'(CAUSE_ST);
         XF_EXT:   cause = 5'(CAUSE_GEN);
         XF_LDCAP: cause = 5'(CAUSE_LD);
         default:  fault = 1'b0;
      endcase
   end
endmodule

// File: rtl/cpf_tag_resolve.sv
module cpf_tag_resolve
   import cpf_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     active,
   input  ld_mode_e mode,
   input  logic     ret_tag,
   input  logic     auth,
   output logic     tag_out,
   output logic     trap
);
   always_comb begin
      tag_out = ret_tag;
      trap    = 1'b0;
      if (ret_tag) begin
         unique case (mode)
            LM_OK:    tag_out = auth;
            LM_CLEAR: tag_out = 1'b0;
            default: begin
               tag_out = 1'b0;
               trap    = auth;
            end
         endcase
      end
   end

   AST_TRAP_NEEDS_TAG: assert property (@(posedge clk) disable iff (!rst_n)
      (active && trap) |-> (ret_tag && auth && mode[1])) else $error("trap without cause"); // R9
endmodule

// File: rtl/cap_pte_filter.sv
module cap_pte_filter
   import cpf_pkg::*;
#(
   parameter int XLEN      = 64,
   parameter int CAP_W     = 128,
   parameter int CAUSE_LD  = 26,
   parameter int CAUSE_ST  = 27,
   parameter int CAUSE_GEN = 28,
   parameter bit HAS_LR    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_tag_dep_trap,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic             req_store,
   input  logic             req_lr,
   input  logic [XLEN-1:0]  req_vaddr,
   input  logic             req_auth_lc,
   input  logic [1:0]       req_ld_mode,
   input  logic             req_st_trap,
   input  logic [1:0]       req_xlat,
   input  logic             req_st_tag,
   input  logic [CAP_W-1:0] req_st_data,
   output logic             mem_rd_en,
   output logic             mem_wr_en,
   output logic [XLEN-1:0]  mem_addr,
   output logic             mem_wr_tag,
   output logic [CAP_W-1:0] mem_wr_data,
   input  logic             mem_rd_valid,
   input  logic             mem_rd_tag,
   input  logic [CAP_W-1:0] mem_rd_data,
   output logic             ld_valid,
   output logic             ld_tag,
   output logic [CAP_W-1:0] ld_data,
   output logic             st_done,
   output logic             exc_valid,
   output logic [4:0]       exc_cause,
   output logic [XLEN-1:0]  exc_tval,
   output logic             resv_set,
   output logic [XLEN-1:0]  resv_addr
);
   localparam int CAUSE_LIM = 1 << 5;

   if (XLEN < 32 || CAP_W < XLEN) begin : g_bad_width
      $error("cap_pte_filter: XLEN must be >= 32 and CAP_W >= XLEN");
   end
   if (CAUSE_LD >= CAUSE_LIM || CAUSE_ST >= CAUSE_LIM || CAUSE_GEN >= CAUSE_LIM) begin : g_bad_range
      $error("cap_pte_filter: cause codes must fit in 5 bits");
   end
   if (CAUSE_LD == CAUSE_ST || CAUSE_LD == CAUSE_GEN || CAUSE_ST == CAUSE_GEN) begin : g_bad_dup
      $error("cap_pte_filter: cause codes must be distinct");
   end

   fsm_e            state;
   logic [XLEN-1:0] vaddr_q;
   logic            auth_q;
   ld_mode_e        mode_q;
   logic            lr_q;
   logic            resv_q;

   logic            xl_fault;
   logic [4:0]      xl_cause;
   logic            rs_tag;
   logic            rs_trap;
   logic            accept;
   logic            pre_trap;

   assign req_ready = (state == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign pre_trap  = !cfg_tag_dep_trap && req_auth_lc && req_ld_mode[1];
   assign mem_addr  = vaddr_q;
   assign resv_addr = vaddr_q;

   cpf_xlat_map #(
      .CAUSE_LD (CAUSE_LD),
      .CAUSE_ST (CAUSE_ST),
      .CAUSE_GEN(CAUSE_GEN)
   ) u_xlat_map (
      .code (xlat_code_e'(req_xlat)),
      .fault(xl_fault),
      .cause(xl_cause)
   );

   cpf_tag_resolve u_resolve (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (state == ST_WAIT && mem_rd_valid),
      .mode   (mode_q),
      .ret_tag(mem_rd_tag),
      .auth   (auth_q),
      .tag_out(rs_tag),
      .trap   (rs_trap)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         vaddr_q     <= '0;
         auth_q      <= 1'b0;
         mode_q      <= LM_OK;
         lr_q        <= 1'b0;
         mem_rd_en   <= 1'b0;
         mem_wr_en   <= 1'b0;
         mem_wr_tag  <= 1'b0;
         mem_wr_data <= '0;
         ld_valid    <= 1'b0;
         ld_tag      <= 1'b0;
         ld_data     <= '0;
         st_done     <= 1'b0;
         exc_valid   <= 1'b0;
         exc_cause   <= '0;
         exc_tval    <= '0;
         resv_q      <= 1'b0;
      end else begin
         mem_rd_en <= 1'b0;
         mem_wr_en <= 1'b0;
         ld_valid  <= 1'b0;
         st_done   <= 1'b0;
         exc_valid <= 1'b0;
         resv_q    <= 1'b0;
         unique case (state)
            ST_IDLE: if (accept) begin
               vaddr_q <= req_vaddr;
               auth_q  <= req_auth_lc;
               mode_q  <= ld_mode_e'(req_ld_mode);
               lr_q    <= req_lr;
               if (xl_fault) begin
                  exc_valid <= 1'b1;
                  exc_cause <= xl_cause;
                  exc_tval  <= req_vaddr;
               end else if (req_store) begin
                  if (req_st_tag && req_st_trap) begin
                     exc_valid <= 1'b1;
                     exc_cause <= 5'(CAUSE_ST);
                     exc_tval  <= req_vaddr;
                  end else begin
                     mem_wr_en   <= 1'b1;
                     mem_wr_tag  <= req_st_tag;
                     mem_wr_data <= req_st_data;
                     st_done     <= 1'b1;
                  end
               end else if (pre_trap) begin
                  exc_valid <= 1'b1;
                  exc_cause <= 5'(CAUSE_LD);
                  exc_tval  <= req_vaddr;
               end else begin
                  mem_rd_en <= 1'b1;
                  state     <= ST_WAIT;
               end
            end
            ST_WAIT: if (mem_rd_valid) begin
               state <= ST_IDLE;
               if (rs_trap) begin
                  exc_valid <= 1'b1;
                  exc_cause <= 5'(CAUSE_LD);
                  exc_tval  <= vaddr_q;
               end else begin
                  ld_valid <= 1'b1;
                  ld_tag   <= rs_tag;
                  ld_data  <= mem_rd_data;
                  resv_q   <= lr_q;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   if (HAS_LR) begin : g_resv
      assign resv_set = resv_q;
   end else begin : g_no_resv
      assign resv_set = 1'b0;
   end

   AST_FAULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |-> !(ld_valid || st_done)) else $error("fault with success"); // R10
   AST_XLAT_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && req_xlat != 2'd0) |=> (exc_valid && !mem_rd_en && !mem_wr_en)) else $error("translation fault leaked"); // R2
   AST_TAGGED_STORE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && req_store && req_xlat == 2'd0 && req_st_tag && req_st_trap)
      |=> (exc_valid && !mem_wr_en && exc_cause == 5'(CAUSE_ST))) else $error("tagged store not blocked"); // R3
   AST_UNTAGGED_STORE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && req_store && req_xlat == 2'd0 && !req_st_tag) |=> (mem_wr_en && st_done)) else $error("untagged store blocked"); // R4
   AST_PRECHECK_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !req_store && req_xlat == 2'd0 && !cfg_tag_dep_trap && req_auth_lc && req_ld_mode[1])
      |=> (exc_valid && !mem_rd_en)) else $error("read issued before early trap"); // R5
   AST_RESV_ON_SUCCESS: assert property (@(posedge clk) disable iff (!rst_n)
      resv_set |-> (ld_valid && !exc_valid)) else $error("reservation without load"); // R11
endmodule

// File: tb/cap_pte_filter_tb_top.sv
module cap_pte_filter_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int XLEN  = 64;
   localparam int CAP_W = 128;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_tag_dep_trap = 1'b0;
   logic             req_valid = 1'b0;
   logic             req_ready;
   logic             req_store = 1'b0;
   logic             req_lr = 1'b0;
   logic [XLEN-1:0]  req_vaddr = '0;
   logic             req_auth_lc = 1'b0;
   logic [1:0]       req_ld_mode = 2'b00;
   logic             req_st_trap = 1'b0;
   logic [1:0]       req_xlat = 2'b00;
   logic             req_st_tag = 1'b0;
   logic [CAP_W-1:0] req_st_data = '0;
   logic             mem_rd_en, mem_wr_en, mem_wr_tag;
   logic [XLEN-1:0]  mem_addr;
   logic [CAP_W-1:0] mem_wr_data;
   logic             mem_rd_valid = 1'b0;
   logic             mem_rd_tag = 1'b0;
   logic [CAP_W-1:0] mem_rd_data = '0;
   logic             ld_valid, ld_tag, st_done, exc_valid, resv_set;
   logic [CAP_W-1:0] ld_data;
   logic [4:0]       exc_cause;
   logic [XLEN-1:0]  exc_tval, resv_addr;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cap_pte_filter #(.XLEN(XLEN), .CAP_W(CAP_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_tag_dep_trap(cfg_tag_dep_trap),
      .req_valid(req_valid), .req_ready(req_ready), .req_store(req_store),
      .req_lr(req_lr), .req_vaddr(req_vaddr), .req_auth_lc(req_auth_lc),
      .req_ld_mode(req_ld_mode), .req_st_trap(req_st_trap), .req_xlat(req_xlat),
      .req_st_tag(req_st_tag), .req_st_data(req_st_data),
      .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
      .mem_wr_tag(mem_wr_tag), .mem_wr_data(mem_wr_data),
      .mem_rd_valid(mem_rd_valid), .mem_rd_tag(mem_rd_tag), .mem_rd_data(mem_rd_data),
      .ld_valid(ld_valid), .ld_tag(ld_tag), .ld_data(ld_data), .st_done(st_done),
      .exc_valid(exc_valid), .exc_cause(exc_cause), .exc_tval(exc_tval),
      .resv_set(resv_set), .resv_addr(resv_addr)
   );

   task automatic check(string req, logic [CAP_W-1:0] act, logic [CAP_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [4:0] xlat_cause(logic [1:0] code);
      case (code)
         2'd1:    return 5'd27;
         2'd2:    return 5'd28;
         default: return 5'd26;
      endcase
   endfunction

   function automatic logic [CAP_W-1:0] rnd_cap();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   // expected tag of a delivered load; trap reported separately
   function automatic logic exp_tag(logic [1:0] mode, logic rtag, logic auth);
      if (!rtag) return 1'b0;
      if (mode == 2'b00) return auth;
      return 1'b0;
   endfunction

   task automatic access(logic st, logic lr, logic [XLEN-1:0] va, logic auth,
                         logic [1:0] mode, logic sttrap, logic [1:0] xl,
                         logic sttag, logic [CAP_W-1:0] sdata, logic dep,
                         logic rtag, logic [CAP_W-1:0] rdata, int gap);
      @(negedge clk);
      cfg_tag_dep_trap = dep;
      req_valid = 1'b1; req_store = st; req_lr = lr; req_vaddr = va;
      req_auth_lc = auth; req_ld_mode = mode; req_st_trap = sttrap;
      req_xlat = xl; req_st_tag = sttag; req_st_data = sdata;
      @(posedge clk); #1;
      if (xl != 2'd0) begin
         check("R2 exc_valid", exc_valid, 1);
         check("R2 cause", exc_cause, xlat_cause(xl));
         check("R2 no access", {mem_rd_en, mem_wr_en}, 0);
         check("R10 tval", exc_tval, va);
      end else if (st) begin
         if (sttag && sttrap) begin
            check("R3 exc", {exc_valid, mem_wr_en, st_done}, 3'b100);
            check("R3 cause", exc_cause, 27);
            check("R10 tval", exc_tval, va);
         end else begin
            check("R4 write", {mem_wr_en, st_done, exc_valid, mem_rd_en}, 4'b1100);
            check("R4 addr", mem_addr, va);
            check("R4 tag", mem_wr_tag, sttag);
            check("R4 data", mem_wr_data, sdata);
         end
      end else if (!dep && auth && mode[1]) begin
         check("R5 early trap", {exc_valid, mem_rd_en}, 2'b10);
         check("R5 cause", exc_cause, 26);
         check("R10 tval", exc_tval, va);
      end else begin
         check("R6 read", {mem_rd_en, exc_valid, ld_valid}, 3'b100);
         check("R6 addr", mem_addr, va);
         @(negedge clk);
         req_valid = 1'b0;
         for (int i = 0; i < gap; i++) begin
            @(posedge clk); #1;
            check("R6 waiting", {ld_valid, exc_valid, mem_rd_en, req_ready}, 4'b0000);
            @(negedge clk);
         end
         mem_rd_valid = 1'b1; mem_rd_tag = rtag; mem_rd_data = rdata;
         @(posedge clk); #1;
         if (rtag && mode[1] && auth) begin
            check("R9 trap", {exc_valid, ld_valid, resv_set}, 3'b100);
            check("R9 cause", exc_cause, 26);
            check("R10 tval", exc_tval, va);
         end else begin
            check(!rtag ? "R6 untagged" : mode == 2'b00 ? "R7 ok" : mode == 2'b01 ? "R8 clear" : "R9 noauth",
                  {ld_valid, exc_valid, ld_tag}, {2'b10, exp_tag(mode, rtag, auth)});
            check("R8 data", ld_data, rdata);
            check("R11 resv", resv_set, lr);
            if (lr) check("R11 addr", resv_addr, va);
         end
         if (exc_valid) check("R11 no resv", resv_set, 0);
      end
      @(negedge clk);
      req_valid = 1'b0; mem_rd_valid = 1'b0;
      @(posedge clk); #1;
      check("R10 pulse", {exc_valid, ld_valid, st_done, mem_wr_en, mem_rd_en, resv_set}, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_c0de));
      repeat (3) @(posedge clk);
      #1;
      check("R1 reset outputs", {ld_valid, st_done, exc_valid, resv_set, mem_rd_en, mem_wr_en}, 0);
      check("R1 ready", req_ready, 1);
      @(negedge clk); rst_n = 1'b1;

      // directed corners
      for (int x = 1; x < 4; x++) begin
         access(1'b1, 0, 64'h1000 + x, 1, 2'b00, 0, 2'(x), 0, rnd_cap(), 1, 0, '0, 0);
         access(1'b0, 0, 64'h2000 + x, 1, 2'b00, 0, 2'(x), 0, '0, 1, 0, '0, 0);
      end
      access(1, 0, 64'hA0, 0, 0, 1, 0, 1, rnd_cap(), 1, 0, '0, 0);        // R3
      access(1, 0, 64'hA8, 0, 0, 1, 0, 0, rnd_cap(), 1, 0, '0, 0);        // R4 untagged, trap page
      access(1, 0, 64'hB0, 0, 0, 0, 0, 1, rnd_cap(), 1, 0, '0, 0);        // R4 tagged, open page
      access(0, 0, 64'hC0, 1, 2'b10, 0, 0, 0, '0, 0, 1, rnd_cap(), 0);    // R5
      access(0, 0, 64'hC8, 0, 2'b10, 0, 0, 0, '0, 0, 1, rnd_cap(), 1);    // R9 no auth
      access(0, 1, 64'hD0, 1, 2'b11, 0, 0, 0, '0, 1, 1, rnd_cap(), 3);    // R9 trap late, lr
      access(0, 1, 64'hD8, 1, 2'b10, 0, 0, 0, '0, 1, 0, rnd_cap(), 2);    // R6 untagged in trap
      access(0, 0, 64'hE0, 1, 2'b00, 0, 0, 0, '0, 1, 1, rnd_cap(), 0);    // R7
      access(0, 1, 64'hE8, 0, 2'b00, 0, 0, 0, '0, 1, 1, rnd_cap(), 0);    // R7 auth clear
      access(0, 1, 64'hF0, 1, 2'b01, 0, 0, 0, '0, 1, 1, rnd_cap(), 1);    // R8

      for (int n = 0; n < 400; n++) begin
         logic [1:0] xl;
         xl = ($urandom % 5 == 0) ? 2'($urandom) : 2'd0;
         access(1'($urandom), 1'($urandom), {$urandom, $urandom}, 1'($urandom),
                ($urandom % 2) ? 2'b10 | 2'($urandom % 2) : 2'($urandom),
                1'($urandom), xl, 1'($urandom), rnd_cap(), 1'($urandom),
                1'($urandom % 4 != 0), rnd_cap(), int'($urandom % 4));
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule